// File: doc/BRIEF.md
# Transmit Descriptor Chain Poller

This block keeps a current descriptor pointer for each of 32 transmit channels and walks each channel's linked list of descriptors in host memory. A descriptor is three 32-bit words: a parameter word at the pointer, a payload address at pointer + 4, and the address of the following descriptor at pointer + 8. The block visits the channels in turn, 0 to 31 and back to 0. Each visit does one polling step for that channel over a single-outstanding memory read port.

Each channel alternates between two phases. In the consume phase the block reads the parameter word. If the host has cleared the hold flag, the block reads the payload address. It then offers the byte count, the payload address and the channel number to a downstream transmitter through a valid/ready pair. If the descriptor ends a frame, it also pulses a frame interrupt request. In the advance phase the block reads the same parameter word again. Once hold is clear, it replaces the channel pointer with the next-descriptor word.

An action engine starts a channel by writing its start pointer. The pointer last used for a consume-phase read of any channel can be read back through a select/data pair.

Top module: `tx_chain_poller`

## Requirements
- R1: After reset `tx_valid`, `irq_valid` and `mem_req` are low, every channel pointer is zero, and every mirror register reads zero.
- R2: In the parameter word, bit 31 is frame end, bit 30 is hold and bits 28:16 are the byte count. All other bits of that word have no effect on any output.
- R3: In the consume phase the block reads the word at the channel pointer. When hold is 0 it then reads pointer + 4. It presents `tx_len` = byte count, `tx_ptr` = the word read at pointer + 4 and `tx_chan` = channel, and the channel enters the advance phase.
- R4: A consume-phase read that finds hold = 1 emits nothing. The channel retries on its next visit.
- R5: In the advance phase the block re-reads the word at the pointer. When hold is 0 it reads pointer + 8, loads that word as the new pointer and returns the channel to the consume phase. When hold is 1 the channel stays in the advance phase.
- R6: A consumed descriptor with frame end set raises `irq_valid` for one cycle. In that cycle `tx_valid` rises, and `irq_word` has bit 12 set, the channel number in bits 4:0 and every other bit zero. A descriptor without frame end raises no interrupt.
- R7: A channel whose pointer is zero issues no memory read.
- R8: Channels are visited in ascending order, wrapping from 31 to 0, with one polling step per visit.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_len`, `tx_ptr` and `tx_chan` hold steady. Consume-phase visits in that time issue no memory read.
- R10: Each consume-phase read copies the channel pointer into that channel's mirror register. `mir_ptr` shows the mirror of channel `mir_sel` combinationally.
- R11: A load sets the channel pointer to `ld_ptr` and puts the channel in the consume phase. If the load targets the channel being visited, that visit changes no state and emits nothing.
- R12: `mem_req` is a one-cycle pulse, and no new request is issued until `mem_rvalid` has returned the previous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Start-pointer load strobe |
| ld_chan | input | 5 | Channel to load |
| ld_ptr | input | 32 | Start descriptor address |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Descriptor offered to transmitter |
| tx_ready | input | 1 | Transmitter accepts the offer |
| tx_len | output | 13 | Byte count |
| tx_ptr | output | 32 | Payload address |
| tx_chan | output | 5 | Channel of the offer |
| irq_valid | output | 1 | Frame interrupt request pulse |
| irq_word | output | 32 | Interrupt code: bit 12 plus channel |
| mir_sel | input | 5 | Mirror register select |
| mir_ptr | output | 32 | Selected mirror register |

## Verification
On every cycle the assertions check four things:
- a stalled offer keeps its fields,
- requests are single-cycle pulses,
- an interrupt coincides with a fresh offer whose channel it names,
- a load or pointer update lands in the channel's storage on the next cycle.

The bench scenarios cover the rest, because these behaviours span many visits and depend on memory contents:
- the three-word layout,
- blocking by the hold flag in both phases,
- visit order,
- skipping of zero pointers,
- absence of reads while an offer is pending,
- the phase reset caused by a load.

// File: rtl/txp_pkg.sv
package txp_pkg;
    localparam int WORD_W   = 32;
    localparam int FE_BIT   = 31;
    localparam int HOLD_BIT = 30;
    localparam int LEN_LSB  = 16;
    localparam int LEN_W    = 13;
    localparam int FI_BIT   = 12;

    typedef enum logic [2:0] {
        S_SCAN,
        S_PAR0,
        S_DPTR,
        S_PAR1,
        S_NEXT
    } walk_st_e;
endpackage

// File: rtl/txp_ctx_bank.sv
module txp_ctx_bank #(
    parameter int NUM_CH = 32,
    parameter int AW     = 32,
    localparam int CHW   = $clog2(NUM_CH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_valid,
    input  logic [CHW-1:0] ld_chan,
    input  logic [AW-1:0]  ld_ptr,
    input  logic           upd_valid,
    input  logic [CHW-1:0] upd_chan,
    input  logic [AW-1:0]  upd_ptr,
    input  logic           upd_phase,
    input  logic           mir_we,
    input  logic [CHW-1:0] mir_chan,
    input  logic [AW-1:0]  mir_val,
    input  logic [CHW-1:0] rd_chan,
    output logic [AW-1:0]  rd_ptr,
    output logic           rd_phase,
    input  logic [CHW-1:0] sel_chan,
    output logic [AW-1:0]  sel_mirror
);
    typedef struct packed {
        logic [NUM_CH-1:0][AW-1:0] cur;
        logic [NUM_CH-1:0]         phase;
        logic [NUM_CH-1:0][AW-1:0] mir;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (upd_valid) begin
            s_d.cur[upd_chan]   = upd_ptr;
            s_d.phase[upd_chan] = upd_phase;
        end
        if (mir_we) begin
            s_d.mir[mir_chan] = mir_val;
        end
        // a load from the action engine overrides any walker update
        if (ld_valid) begin
            s_d.cur[ld_chan]   = ld_ptr;
            s_d.phase[ld_chan] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_ptr     = s_q.cur[rd_chan];
    assign rd_phase   = s_q.phase[rd_chan];
    assign sel_mirror = s_q.mir[sel_chan];

    assert_load_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (s_q.cur[$past(ld_chan)] == $past(ld_ptr)) && !s_q.phase[$past(ld_chan)]);

    assert_update_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !(ld_valid && ld_chan == upd_chan))
        |=> (s_q.cur[$past(upd_chan)] == $past(upd_ptr)) && (s_q.phase[$past(upd_chan)] == $past(upd_phase)));
endmodule

// File: rtl/txp_walker.sv
module txp_walker
    import txp_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int AW     = 32,
    localparam int CHW   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [CHW-1:0]    ld_chan,
    output logic [CHW-1:0]    rd_chan,
    input  logic [AW-1:0]     rd_ptr,
    input  logic              rd_phase,
    output logic              upd_valid,
    output logic [CHW-1:0]    upd_chan,
    output logic [AW-1:0]     upd_ptr,
    output logic              upd_phase,
    output logic              mir_we,
    output logic [CHW-1:0]    mir_chan,
    output logic [AW-1:0]     mir_val,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [LEN_W-1:0]  tx_len,
    output logic [AW-1:0]     tx_ptr,
    output logic [CHW-1:0]    tx_chan,
    output logic              irq_valid,
    output logic [WORD_W-1:0] irq_word
);
    typedef struct packed {
        walk_st_e          st;
        logic [CHW-1:0]    ch;
        logic              ld_hit;
        logic              par_fe;
        logic [LEN_W-1:0]  par_len;
        logic              mem_req;
        logic [AW-1:0]     mem_addr;
        logic              tx_valid;
        logic [LEN_W-1:0]  tx_len;
        logic [AW-1:0]     tx_ptr;
        logic [CHW-1:0]    tx_chan;
        logic              irq_valid;
        logic [WORD_W-1:0] irq_word;
    } walk_t;

    walk_t w_d, w_q;
    logic  hit_now;
    logic  advance;

    always_comb begin
        w_d       = w_q;
        w_d.mem_req   = 1'b0;
        w_d.irq_valid = 1'b0;
        upd_valid = 1'b0;
        upd_chan  = w_q.ch;
        upd_ptr   = rd_ptr;
        upd_phase = rd_phase;
        mir_we    = 1'b0;
        mir_chan  = w_q.ch;
        mir_val   = rd_ptr;
        advance   = 1'b0;
        hit_now   = ld_valid && (ld_chan == w_q.ch);
        w_d.ld_hit = w_q.ld_hit | hit_now;
        if (w_q.tx_valid && tx_ready) w_d.tx_valid = 1'b0;

        unique case (w_q.st)
            S_SCAN: begin
                if (hit_now || rd_ptr == '0) begin
                    advance = 1'b1;
                end else if (!rd_phase) begin
                    if (w_q.tx_valid) begin
                        advance = 1'b1;
                    end else begin
                        mir_we       = 1'b1;
                        w_d.mem_req  = 1'b1;
                        w_d.mem_addr = rd_ptr;
                        w_d.st       = S_PAR0;
                    end
                end else begin
                    w_d.mem_req  = 1'b1;
                    w_d.mem_addr = rd_ptr;
                    w_d.st       = S_PAR1;
                end
            end
            S_PAR0: if (mem_rvalid) begin
                w_d.par_fe  = mem_rdata[FE_BIT];
                w_d.par_len = mem_rdata[LEN_LSB +: LEN_W];
                if (w_d.ld_hit || mem_rdata[HOLD_BIT]) begin
                    advance = 1'b1;
                end else begin
                    w_d.mem_req  = 1'b1;
                    w_d.mem_addr = rd_ptr + AW'(4);
                    w_d.st       = S_DPTR;
                end
            end
            S_DPTR: if (mem_rvalid) begin
                if (!w_d.ld_hit) begin
                    w_d.tx_valid = 1'b1;
                    w_d.tx_len   = w_q.par_len;
                    w_d.tx_ptr   = AW'(mem_rdata);
                    w_d.tx_chan  = w_q.ch;
                    if (w_q.par_fe) begin
                        w_d.irq_valid         = 1'b1;
                        w_d.irq_word          = '0;
                        w_d.irq_word[FI_BIT]  = 1'b1;
                        w_d.irq_word[CHW-1:0] = w_q.ch;
                    end
                    upd_valid = 1'b1;
                    upd_ptr   = rd_ptr;
                    upd_phase = 1'b1;
                end
                advance = 1'b1;
            end
            S_PAR1: if (mem_rvalid) begin
                if (w_d.ld_hit || mem_rdata[HOLD_BIT]) begin
                    advance = 1'b1;
                end else begin
                    w_d.mem_req  = 1'b1;
                    w_d.mem_addr = rd_ptr + AW'(8);
                    w_d.st       = S_NEXT;
                end
            end
            S_NEXT: if (mem_rvalid) begin
                if (!w_d.ld_hit) begin
                    upd_valid = 1'b1;
                    upd_ptr   = AW'(mem_rdata);
                    upd_phase = 1'b0;
                end
                advance = 1'b1;
            end
            default: advance = 1'b1;
        endcase

        if (advance) begin
            w_d.st     = S_SCAN;
            w_d.ld_hit = 1'b0;
            w_d.ch     = (w_q.ch == CHW'(NUM_CH - 1)) ? '0 : w_q.ch + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q    <= '0;
            w_q.st <= S_SCAN;
        end else begin
            w_q <= w_d;
        end
    end

    assign rd_chan   = w_q.ch;
    assign mem_req   = w_q.mem_req;
    assign mem_addr  = w_q.mem_addr;
    assign tx_valid  = w_q.tx_valid;
    assign tx_len    = w_q.tx_len;
    assign tx_ptr    = w_q.tx_ptr;
    assign tx_chan   = w_q.tx_chan;
    assign irq_valid = w_q.irq_valid;
    assign irq_word  = w_q.irq_word;

    assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_offer_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_ptr) && $stable(tx_len) && $stable(tx_chan));

    assert_irq_with_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $rose(tx_valid));

    assert_irq_names_chan_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> irq_word[FI_BIT] && (irq_word[CHW-1:0] == tx_chan));
endmodule

// File: rtl/tx_chain_poller.sv
module tx_chain_poller
    import txp_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int AW     = 32,
    localparam int CHW   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [CHW-1:0]    ld_chan,
    input  logic [AW-1:0]     ld_ptr,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [LEN_W-1:0]  tx_len,
    output logic [AW-1:0]     tx_ptr,
    output logic [CHW-1:0]    tx_chan,
    output logic              irq_valid,
    output logic [WORD_W-1:0] irq_word,
    input  logic [CHW-1:0]    mir_sel,
    output logic [AW-1:0]     mir_ptr
);
    logic [CHW-1:0] rd_chan;
    logic [AW-1:0]  rd_ptr;
    logic           rd_phase;
    logic           upd_valid;
    logic [CHW-1:0] upd_chan;
    logic [AW-1:0]  upd_ptr;
    logic           upd_phase;
    logic           mir_we;
    logic [CHW-1:0] mir_chan;
    logic [AW-1:0]  mir_val;

    txp_ctx_bank #(.NUM_CH(NUM_CH), .AW(AW)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_chan   (ld_chan),
        .ld_ptr    (ld_ptr),
        .upd_valid (upd_valid),
        .upd_chan  (upd_chan),
        .upd_ptr   (upd_ptr),
        .upd_phase (upd_phase),
        .mir_we    (mir_we),
        .mir_chan  (mir_chan),
        .mir_val   (mir_val),
        .rd_chan   (rd_chan),
        .rd_ptr    (rd_ptr),
        .rd_phase  (rd_phase),
        .sel_chan  (mir_sel),
        .sel_mirror(mir_ptr)
    );

    txp_walker #(.NUM_CH(NUM_CH), .AW(AW)) i_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_chan   (ld_chan),
        .rd_chan   (rd_chan),
        .rd_ptr    (rd_ptr),
        .rd_phase  (rd_phase),
        .upd_valid (upd_valid),
        .upd_chan  (upd_chan),
        .upd_ptr   (upd_ptr),
        .upd_phase (upd_phase),
        .mir_we    (mir_we),
        .mir_chan  (mir_chan),
        .mir_val   (mir_val),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_len    (tx_len),
        .tx_ptr    (tx_ptr),
        .tx_chan   (tx_chan),
        .irq_valid (irq_valid),
        .irq_word  (irq_word)
    );
endmodule

// File: tb/test_tx_chain_poller.sv
module test_tx_chain_poller;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [4:0]  ld_chan = '0;
    logic [31:0] ld_ptr = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [12:0] tx_len;
    logic [31:0] tx_ptr;
    logic [4:0]  tx_chan;
    logic        irq_valid;
    logic [31:0] irq_word;
    logic [4:0]  mir_sel = '0;
    logic [31:0] mir_ptr;

    tx_chain_poller i_tx_chain_poller (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_chan(ld_chan), .ld_ptr(ld_ptr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_len(tx_len), .tx_ptr(tx_ptr), .tx_chan(tx_chan),
        .irq_valid(irq_valid), .irq_word(irq_word), .mir_sel(mir_sel), .mir_ptr(mir_ptr)
    );

    always #10 clk = ~clk;

    // host memory model: fixed two-cycle read latency
    logic [31:0] mem [0:255];
    logic        p1_v = 1'b0;
    logic [31:0] p1_a = '0;
    always @(posedge clk) begin
        p1_v       <= mem_req;
        p1_a       <= mem_addr;
        mem_rvalid <= p1_v;
        mem_rdata  <= mem[p1_a[9:2]];
    end

    int checks = 0;
    int errors = 0;
    int tx_done = 0;
    int irq_cnt = 0;
    int req_cnt = 0;
    int watch_hits = 0;
    logic [31:0] watch_addr = 32'hFFFF_FFFF;
    bit   logging = 0;
    int   addr_log[$];
    logic [49:0] exp_tx[$];
    logic [31:0] exp_irq[$];
    bit   outstanding = 0;
    bit   prev_stall = 0;
    logic [49:0] prev_offer = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rvalid) outstanding = 0;
            if (mem_req) begin
                if (outstanding) chk(0, "R12", "request while read outstanding", 1, 0);
                outstanding = 1;
                req_cnt++;
                if (mem_addr == watch_addr) watch_hits++;
                if (logging) addr_log.push_back(int'(mem_addr));
            end
            if (prev_stall)
                chk(tx_valid && {tx_chan, tx_len, tx_ptr} == prev_offer, "R9", "stalled offer changed",
                    {tx_chan, tx_len, tx_ptr}, prev_offer);
            prev_stall = tx_valid && !tx_ready;
            prev_offer = {tx_chan, tx_len, tx_ptr};
            if (irq_valid) begin
                irq_cnt++;
                chk(tx_valid, "R6", "irq without offer", tx_valid, 1);
                if (exp_irq.size() == 0) chk(0, "R6", "unexpected irq", irq_word, 0);
                else begin
                    logic [31:0] e;
                    e = exp_irq.pop_front();
                    chk(irq_word == e, "R6", "irq word", irq_word, e);
                end
            end
            if (tx_valid && tx_ready) begin
                tx_done++;
                if (exp_tx.size() == 0) chk(0, "R3", "unexpected offer", {tx_chan, tx_len, tx_ptr}, 0);
                else begin
                    logic [49:0] e;
                    e = exp_tx.pop_front();
                    chk({tx_chan, tx_len, tx_ptr} == e, "R3", "offer chan/len/ptr", {tx_chan, tx_len, tx_ptr}, e);
                end
            end
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 150000, 0);
        summary();
        $finish;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // noise pattern in bits 29, 15, 11 and 8:0 that must not matter (R2)
    task automatic put_desc(input int a, input bit fe, input bit hold, input int len,
                            input int dp, input int nxt);
        mem[a >> 2]       = (32'(fe) << 31) | (32'(hold) << 30) | ((32'(len) & 32'h1FFF) << 16) | 32'h2000_89A5;
        mem[(a >> 2) + 1] = dp;
        mem[(a >> 2) + 2] = nxt;
    endtask

    task automatic load(input int ch, input int p);
        @(negedge clk);
        ld_valid = 1; ld_chan = 5'(ch); ld_ptr = p;
        @(negedge clk);
        ld_valid = 0;
    endtask

    task automatic wait_tx(input int n, input string req);
        for (int i = 0; i < 4000 && tx_done < n; i++) @(negedge clk);
        chk(tx_done >= n, req, "offer count", tx_done, n);
    endtask

    function automatic int chan_of(input int a);
        case (a)
            32'h180: return 1;
            32'h1C0: return 7;
            32'h200: return 20;
            default: return -1;
        endcase
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        cycles(5);
        rst_n = 1;
        mir_sel = 5'd3;
        cycles(1);
        chk(!tx_valid && !irq_valid && !mem_req, "R1", "outputs after reset",
            {tx_valid, irq_valid, mem_req}, 0);
        chk(mir_ptr == 0, "R1", "mirror after reset", mir_ptr, 0);

        req_cnt = 0;
        cycles(200);
        chk(req_cnt == 0, "R7", "reads with all pointers zero", req_cnt, 0);

        // chain on channel 3: frame-end descriptor, then one under hold
        put_desc(32'h40, 1, 0, 100, 32'h1000, 32'h80);
        put_desc(32'h80, 0, 1, 20, 32'h2000, 0);
        exp_tx.push_back({5'd3, 13'd100, 32'h1000});
        exp_irq.push_back(32'h0000_1003);
        load(3, 32'h40);
        wait_tx(1, "R3");
        cycles(400);
        chk(tx_done == 1, "R4", "emitted while hold set", tx_done, 1);
        chk(mir_ptr == 32'h80, "R10", "mirror follows next pointer (R5)", mir_ptr, 32'h80);
        exp_tx.push_back({5'd3, 13'd20, 32'h2000});
        mem[32'h80 >> 2][30] = 1'b0;
        wait_tx(2, "R4");
        cycles(300);
        chk(irq_cnt == 1, "R6", "irq for descriptor without frame end", irq_cnt, 1);
        req_cnt = 0;
        cycles(300);
        chk(req_cnt == 0, "R7", "reads after chain reached zero", req_cnt, 0);

        // back-pressure: channel 5 offer stalls, channel 6 must not be read
        tx_ready = 0;
        put_desc(32'h100, 1, 0, 33, 32'h3000, 0);
        put_desc(32'h140, 0, 0, 44, 32'h4000, 0);
        exp_tx.push_back({5'd5, 13'd33, 32'h3000});
        exp_tx.push_back({5'd6, 13'd44, 32'h4000});
        exp_irq.push_back(32'h0000_1005);
        load(5, 32'h100);
        for (int i = 0; i < 4000 && !tx_valid; i++) @(negedge clk);
        chk(tx_valid, "R9", "offer appears", tx_valid, 1);
        watch_hits = 0;
        watch_addr = 32'h140;
        load(6, 32'h140);
        cycles(400);
        chk(watch_hits == 0, "R9", "reads while offer pending", watch_hits, 0);
        chk(tx_valid && tx_chan == 5'd5, "R9", "stalled offer channel", tx_chan, 5);
        tx_ready = 1;
        wait_tx(4, "R9");
        cycles(300);

        // visit order with three channels blocked on hold
        put_desc(32'h180, 0, 1, 1, 32'h10, 0);
        put_desc(32'h1C0, 0, 1, 1, 32'h20, 0);
        put_desc(32'h200, 0, 1, 1, 32'h30, 0);
        load(1, 32'h180);
        load(7, 32'h1C0);
        load(20, 32'h200);
        cycles(200);
        addr_log.delete();
        logging = 1;
        for (int i = 0; i < 4000 && addr_log.size() < 9; i++) @(negedge clk);
        logging = 0;
        begin
            bit ok;
            ok = addr_log.size() >= 9;
            for (int i = 0; ok && i + 1 < addr_log.size(); i++) begin
                int a, b;
                a = chan_of(addr_log[i]);
                b = chan_of(addr_log[i + 1]);
                if (!((a == 1 && b == 7) || (a == 7 && b == 20) || (a == 20 && b == 1))) ok = 0;
            end
            chk(ok, "R8", "cyclic visit order 1,7,20", addr_log.size(), 9);
        end
        chk(tx_done == 4, "R4", "hold-blocked channels emitted", tx_done, 4);
        load(1, 0);
        load(7, 0);
        load(20, 0);
        cycles(200);

        // reload puts an advance-phase channel back into consume phase
        put_desc(32'h240, 0, 0, 7, 32'h5000, 0);
        exp_tx.push_back({5'd9, 13'd7, 32'h5000});
        load(9, 32'h240);
        wait_tx(5, "R3");
        mem[32'h240 >> 2][30] = 1'b1;
        cycles(300);
        chk(tx_done == 5, "R5", "advance phase blocked by hold", tx_done, 5);
        exp_tx.push_back({5'd9, 13'd7, 32'h5000});
        load(9, 32'h240);
        mem[32'h240 >> 2][30] = 1'b0;
        wait_tx(6, "R11");
        cycles(100);
        chk(exp_tx.size() == 0 && exp_irq.size() == 0, "R11", "scoreboard drained",
            exp_tx.size() + exp_irq.size(), 0);

        summary();
        $finish;
    end
endmodule